// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the slowly changing frequency-offset word that steers a fractional feedback divider or a numerically controlled oscillator. With this word applied, a synthesized clock sweeps back and forth across a selected band instead of sitting at one frequency. A three-bit width code sets two things: the total excursion, and whether the band lies wholly below nominal or is centred on it. An active-low enable switches the sweep on and off. A programmable period sets how many clock cycles one full sweep takes. The default is a thousand cycles, so the sweep is far slower than the clock.

The offset is signed, in units of 1/100000 of the nominal frequency, so every band edge is a whole number. The sweep is a symmetric triangle. It starts at the low band edge, climbs linearly to the high edge at mid-period, and falls back. A strobe marks the first cycle of every period. New width, enable and period settings are taken only on the last cycle of a period, so a ramp is never cut short. A second offset output feeds the unmodulated reference copy and always stays at zero.

Top module: `ssp_profile_gen`

## Requirements
- R1: The code bits mw_sel[2:1] set the total span S: 00 gives 1250, 01 gives 2500, 10 gives 5000 and 11 gives 10000 units (1 unit = 1/100000 of nominal).
- R2: With mw_sel[0]=0 (down spread) the band runs from -S at its lowest point up to exactly 0.
- R3: With mw_sel[0]=1 (centre spread) the band runs from -S/2 up to +S/2, for example -625..+625 for code 001 and -5000..+5000 for code 111.
- R4: While the latched spread_n is 1 (spread off), offset is 0 for the whole period.
- R5: With H the half period and p the phase (0 at period start), offset equals low + floor(S*L/H), where L = p for p < H and L = 2H - p otherwise.
- R6: One period lasts 2*H cycles, with H = period[PW-1:1], or H = 1 when that field is 0. period_start is 1 exactly on phase 0.
- R7: mw_sel, spread_n and period are sampled only on the last cycle of a period. Changes at any other time have no effect until the following period.
- R8: A synchronous active-high rst sets the phase to 0 and the offset to 0. It also leaves the block in a first period with spread off, code 000 and period DEF_PERIOD.
- R9: ref_offset is 0 at all times, whatever the enable and width code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mw_sel | input | 3 | Width code: [2:1] span, [0] centre (1) or down (0) |
| spread_n | input | 1 | Spread enable, active low |
| period | input | PW | Profile period in cycles (LSB ignored) |
| offset | output | OW | Signed frequency offset, 1/100000 units |
| period_start | output | 1 | High on the first cycle of each period |
| ref_offset | output | OW | Offset for the unmodulated reference path, always 0 |

## Verification
The bench builds the block with PW=16 and OW=16, and lowers DEF_PERIOD to 40. With that value, the first period after each reset ends after 40 cycles and does not hold the run for a thousand. Programmed periods are drawn mostly from 2 to 120. This means hundreds of full triangles complete, and every width code reaches both of its band edges. Directed periods of 0, 1 and 3 exercise the smallest two-cycle sweep, where the offset jumps straight between the edges. Inputs that change in the middle of a ramp exercise the rule that settings are taken only at the period boundary.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Total span in 1/100000 units for the two amplitude bits.
  function automatic int span_of(input logic [1:0] amp);
    case (amp)
      2'b00:   return 1250;
      2'b01:   return 2500;
      2'b10:   return 5000;
      default: return 10000;
    endcase
  endfunction

  // Lowest band point: full span below nominal, or half of it when centred.
  function automatic int band_low(input logic [2:0] code);
    int s;
    s = span_of(code[2:1]);
    return code[0] ? -(s / 2) : -s;
  endfunction

  // Position along the triangle, 0 at the start, half at the peak.
  function automatic int tri_level(input int ph, input int half);
    return (ph < half) ? ph : (2 * half - ph);
  endfunction

  function automatic int offset_of(input logic [2:0] code, input int ph, input int half);
    return band_low(code) + (span_of(code[2:1]) * tri_level(ph, half)) / half;
  endfunction

endpackage

// File: rtl/ssp_cfg_latch.sv
module ssp_cfg_latch #(
  parameter int PW         = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    sel_in,
  input  logic          spread_n_in,
  input  logic [PW-1:0] period_in,
  output logic [2:0]    sel_q,
  output logic          en_q,
  output logic [PW-1:0] half_q
);
  localparam int          DEF_HALF_I = (DEF_PERIOD / 2 < 1) ? 1 : DEF_PERIOD / 2;
  localparam logic [PW-1:0] DEF_HALF = PW'(DEF_HALF_I);

  logic [PW-1:0] half_raw;
  logic [PW-1:0] half_next;

  assign half_raw  = {1'b0, period_in[PW-1:1]};
  assign half_next = (half_raw == '0) ? PW'(1) : half_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 3'b000;
      en_q   <= 1'b0;
      half_q <= DEF_HALF;
    end else if (load) begin
      sel_q  <= sel_in;
      en_q   <= ~spread_n_in;
      half_q <= half_next;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(sel_q) && $stable(en_q) && $stable(half_q))); // R7

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (half_q != '0)); // R6

endmodule

// File: rtl/ssp_phase_ctr.sv
module ssp_phase_ctr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] half,
  output logic [PW:0]   ph,
  output logic          last,
  output logic          start
);
  logic [PW:0] last_idx;

  assign last_idx = {half, 1'b0} - (PW+1)'(1);
  assign last     = (ph == last_idx);
  assign start    = (ph == '0);

  always_ff @(posedge clk) begin
    if (rst || last) ph <= '0;
    else             ph <= ph + (PW+1)'(1);
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    last |=> start); // R6

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R6

endmodule

// File: rtl/ssp_shape.sv
module ssp_shape #(
  parameter int PW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sel,
  input  logic          en,
  input  logic [PW-1:0] half,
  input  logic [PW:0]   ph,
  output logic [OW-1:0] offset
);
  logic [OW-1:0] ramp_val;

  assign ramp_val = OW'(ssp_pkg::offset_of(sel, int'(ph), int'(half)));
  assign offset   = en ? ramp_val : '0;

  AST_DOWN_CEILING: assert property (@(posedge clk) disable iff (rst)
    (en && !sel[0]) |-> ($signed(offset) <= 0 && $signed(offset) >= -10000)); // R2

  AST_CENTRE_BAND: assert property (@(posedge clk) disable iff (rst)
    (en && sel[0]) |-> ($signed(offset) <= 5000 && $signed(offset) >= -5000)); // R3

endmodule

// File: rtl/ssp_profile_gen.sv
module ssp_profile_gen #(
  parameter int PW         = 16,
  parameter int OW         = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mw_sel,
  input  logic          spread_n,
  input  logic [PW-1:0] period,
  output logic [OW-1:0] offset,
  output logic          period_start,
  output logic [OW-1:0] ref_offset
);
  logic [2:0]    sel_q;
  logic          en_q;
  logic [PW-1:0] half_q;
  logic [PW:0]   ph;
  logic          ph_last;

  ssp_cfg_latch #(.PW(PW), .DEF_PERIOD(DEF_PERIOD)) u_cfg (
    .clk(clk), .rst(rst), .load(ph_last),
    .sel_in(mw_sel), .spread_n_in(spread_n), .period_in(period),
    .sel_q(sel_q), .en_q(en_q), .half_q(half_q)
  );

  ssp_phase_ctr #(.PW(PW)) u_phase (
    .clk(clk), .rst(rst), .half(half_q),
    .ph(ph), .last(ph_last), .start(period_start)
  );

  ssp_shape #(.PW(PW), .OW(OW)) u_shape (
    .clk(clk), .rst(rst), .sel(sel_q), .en(en_q),
    .half(half_q), .ph(ph), .offset(offset)
  );

  assign ref_offset = '0;

  AST_OFF_IS_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (offset == '0)); // R4

  AST_START_AT_LOW: assert property (@(posedge clk) disable iff (rst)
    (period_start && en_q && !sel_q[0]) |-> ($signed(offset) < 0)); // R1

endmodule

// File: tb/ssp_profile_gen_bench.sv
module ssp_profile_gen_bench;
  localparam int PW = 16;
  localparam int OW = 16;
  localparam int DEFP = 40;
  localparam int DEFH = DEFP / 2;
  localparam int CYCLES = 30000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mw_sel = 3'b000;
  logic          spread_n = 1'b1;
  logic [PW-1:0] period = PW'(DEFP);
  logic [OW-1:0] offset;
  logic          period_start;
  logic [OW-1:0] ref_offset;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int m_ph, m_half, m_en;
  logic [2:0] m_sel;

  ssp_profile_gen #(.PW(PW), .OW(OW), .DEF_PERIOD(DEFP)) u_ssp_profile_gen (
    .clk(clk), .rst(rst), .mw_sel(mw_sel), .spread_n(spread_n), .period(period),
    .offset(offset), .period_start(period_start), .ref_offset(ref_offset)
  );

  always #5 clk = ~clk;

  function automatic int b_span(input logic [1:0] a);
    return 1250 << a;
  endfunction

  function automatic int b_expect(input logic [2:0] c, input int en, input int p, input int h);
    int sp, lo, lv;
    if (en == 0) return 0;
    sp = b_span(c[2:1]);
    lo = c[0] ? -(sp >> 1) : -sp;
    lv = (p < h) ? p : (2 * h - p);
    return lo + (sp * lv) / h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (phase %0d)", req, act, exp, m_ph);
    end
  endtask

  task automatic model_step();
    int hr;
    if (rst) begin
      m_ph = 0; m_half = DEFH; m_sel = 3'b000; m_en = 0;
    end else if (m_ph == 2 * m_half - 1) begin
      m_ph = 0;
      m_sel = mw_sel;
      m_en = spread_n ? 0 : 1;
      hr = int'(period) >> 1;
      m_half = (hr == 0) ? 1 : hr;
    end else begin
      m_ph++;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tag;
    bit pending;
    void'($urandom(32'h5eed));
    m_ph = 0; m_half = DEFH; m_sel = 3'b000; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: after reset the phase is 0 and offset is 0
    chk("R8 offset", int'($signed(offset)), 0);
    chk("R8 start", int'(period_start), 1);
    spread_n = 1'b0;
    mw_sel = 3'b110;
    period = PW'(24);
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      if (cyc != 0) begin
        @(negedge clk);
        rst = (cyc == 15001) ? 1'b1 : 1'b0;
        if ($urandom % 50 == 0) mw_sel = 3'($urandom % 8);
        if ($urandom % 80 == 0) spread_n = ($urandom % 4 == 0);
        if ($urandom % 60 == 0) begin
          case ($urandom % 10)
            0: period = PW'(0);
            1: period = PW'(1);
            2: period = PW'(3);
            default: period = PW'(2 + $urandom % 119);
          endcase
        end
        if (cyc > 29000) begin
          // directed sweep of the two extreme codes with spread on
          spread_n = 1'b0;
          mw_sel = (cyc < 29500) ? 3'b110 : 3'b001;
          period = PW'(40);
        end
      end
      pending = (mw_sel != m_sel) || ((spread_n ? 0 : 1) != m_en);
      if (m_en == 0)                 tag = "R4";
      else if (m_ph == 0)            tag = m_sel[0] ? "R3 low" : "R1 low";
      else if (m_ph == m_half)       tag = m_sel[0] ? "R3 high" : "R2 high";
      else if (pending)              tag = "R7";
      else                           tag = "R5";
      chk(tag, int'($signed(offset)), b_expect(m_sel, m_en, m_ph, m_half));
      chk("R6 start", int'(period_start), (m_ph == 0) ? 1 : 0);
      chk("R9 ref", int'($signed(ref_offset)), 0);
      model_step();
    end
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule